// File: doc/BRIEF.md
# Redundant Ring Frame Merger

This block sits in a fieldbus master between the receive paths of two Ethernet ports that close a cable-redundant ring. Each cyclic frame leaves on both ports at once. One copy travels the ring forward and the other travels it in reverse. The block keeps the transmitted copy as a reference. It then waits for the two copies to come back and pairs them by their identifier byte.

When the two copies arrive, the block rebuilds one frame byte by byte. A byte that a node changed is kept, and the primary copy wins where both copies changed the same byte. The two working counters are added, and the frame is marked good when the sum matches the working counter expected for that frame. If only one copy arrives before the pairing window closes, that copy is passed on unchanged and the frame is flagged as having lost a copy.

A ring status output reports one of three states: intact, single break, or failed. The failed state stays set until the master reinitialises the ring. The merged frame leaves on a byte stream with a ready/valid handshake.

Top module: `ring_frame_merger`

## Requirements
- R1: After reset, `out_valid` is 0 and `ring_status` is 0 (intact).
- R2: A frame is exactly `N` bytes. Byte 0 is the identifier and byte `N-1` is the 8-bit working counter. A returned copy is ignored if its byte 0 differs from the reference identifier, or if its `last` marker does not fall on byte `N-1`.
- R3: When both copies arrive, merged byte 0 is the reference identifier. For each byte 1..N-2, the merged byte is the primary byte if that byte differs from the reference. Otherwise it is the secondary byte if that byte differs from the reference. Otherwise it is the reference byte.
- R4: When both copies arrive, merged byte `N-1` is the sum modulo 256 of the two working counters. `out_frame_ok` is 1 exactly when that sum equals the expected working counter, and it holds for the whole frame.
- R5: `ring_status` becomes 0 (intact) when both copies arrive, the sum matches, the secondary data bytes equal the reference, and the secondary working counter is 0.
- R6: `ring_status` becomes 1 (single break) when both copies arrive, the sum matches, and the intact condition does not hold.
- R7: `ring_status` becomes 2 (failed) when the working-counter total does not equal the expected value, and the frame is output with `out_frame_ok` at 0.
- R8: If only one valid copy has arrived `TIMEOUT_CYC` cycles after the reference was taken, that copy is output unchanged with `out_lost` at 1. `out_frame_ok` is 1 exactly when its own working counter equals the expected value. The status becomes 1 if the frame is good and 2 if it is not.
- R9: If no valid copy arrives within the window, no frame is output and `ring_status` becomes 2.
- R10: Status 2 is sticky and only a cycle with `init_i` high clears it, back to 0. Outside that state, the status follows each new frame, so a repaired ring returns from 1 to 0.
- R11: `out_data` and `out_last` hold steady while `out_valid` is high and `out_ready` is low. `out_last` marks byte `N-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Ring reinitialisation; clears the failed status |
| tx_valid | input | 1 | Reference byte valid |
| tx_data | input | 8 | Reference byte |
| tx_last | input | 1 | Final reference byte |
| tx_exp_wkc | input | 8 | Expected working counter, sampled with `tx_last` |
| pri_valid | input | 1 | Primary port byte valid |
| pri_data | input | 8 | Primary port byte |
| pri_last | input | 1 | Primary port frame end |
| sec_valid | input | 1 | Secondary port byte valid |
| sec_data | input | 8 | Secondary port byte |
| sec_last | input | 1 | Secondary port frame end |
| out_valid | output | 1 | Merged byte valid |
| out_data | output | 8 | Merged byte |
| out_last | output | 1 | Final merged byte |
| out_ready | input | 1 | Downstream accepts the byte |
| out_frame_ok | output | 1 | Working-counter total matches expected |
| out_lost | output | 1 | Only one copy was used |
| ring_status | output | 2 | 0 intact, 1 single break, 2 failed |

## Verification
The merged frame starts one cycle after the second valid copy's last byte, or one cycle after the pairing window ends. Its bytes are consumed only on handshake cycles, so the bench collects bytes whenever it sees valid and ready together at the falling edge, and it keeps a per-frame wait limit rather than fixed offsets. `ring_status` changes in the same edge that starts the output frame, so the bench reads it only after the whole frame has drained. The no-copy case is observed for the full window plus a margin before the status is read. An `init_i` pulse takes effect on the next edge and is checked half a cycle later.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        RING_INTACT = 2'd0,
        RING_BREAK  = 2'd1,
        RING_FAILED = 2'd2
    } ring_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic  frame_ok;
        logic  lost;
        ring_e status;
    } verdict_t;

    // processed byte wins over the untouched reference; primary first
    function automatic byte_t pick_byte(byte_t ref_b, byte_t pri_b, byte_t sec_b);
        if (pri_b != ref_b)      return pri_b;
        else if (sec_b != ref_b) return sec_b;
        else                     return ref_b;
    endfunction
endpackage

// File: rtl/rfm_capture.sv
module rfm_capture #(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              arm_i,
    input  logic [7:0]        ref_id_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_last_i,
    output logic              have_o,
    output logic [N-1:0][7:0] frame_o
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0]     cnt;
    logic              id_hit;
    logic [N-1:0][7:0] fbuf;

    wire take = arm_i && in_valid_i && !have_o;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt    <= '0;
            have_o <= 1'b0;
            id_hit <= 1'b0;
        end else if (take) begin
            if (cnt == '0) id_hit <= (in_data_i == ref_id_i);
            if (in_last_i) begin
                cnt    <= '0;
                have_o <= (cnt == CW'(N - 1)) && id_hit;
            end else if (cnt != CW'(N)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            for (int i = 0; i < N; i++)
                if (cnt == CW'(i)) fbuf[i] <= in_data_i;
        end
    end

    assign frame_o = fbuf;

    // R2
    have_rise_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(have_o) |-> $past(arm_i && in_valid_i && in_last_i));
endmodule

// File: rtl/rfm_merge.sv
module rfm_merge
    import rfm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0][7:0] ref_i,
    input  logic [N-1:0][7:0] pri_i,
    input  logic [N-1:0][7:0] sec_i,
    input  logic              have_pri_i,
    input  logic              have_sec_i,
    input  logic [7:0]        exp_wkc_i,
    output logic [N-1:0][7:0] merged_o,
    output verdict_t          verdict_o
);
    logic [N-1:0][7:0] both;
    logic [N-1:0]      sec_same;
    logic [7:0]        wkc_sum;

    assign wkc_sum = pri_i[N-1] + sec_i[N-1];
    assign both[0] = ref_i[0];
    assign both[N-1] = wkc_sum;
    assign sec_same[0] = 1'b1;
    assign sec_same[N-1] = 1'b1;

    for (genvar i = 1; i < N - 1; i++) begin : g_byte
        assign both[i]     = pick_byte(ref_i[i], pri_i[i], sec_i[i]);
        assign sec_same[i] = (sec_i[i] == ref_i[i]);
    end

    always_comb begin
        merged_o           = ref_i;
        verdict_o.frame_ok = 1'b0;
        verdict_o.lost     = 1'b1;
        verdict_o.status   = RING_FAILED;
        if (have_pri_i && have_sec_i) begin
            merged_o           = both;
            verdict_o.lost     = 1'b0;
            verdict_o.frame_ok = (wkc_sum == exp_wkc_i);
            if (!verdict_o.frame_ok)                    verdict_o.status = RING_FAILED;
            else if (&sec_same && sec_i[N-1] == 8'd0)   verdict_o.status = RING_INTACT;
            else                                        verdict_o.status = RING_BREAK;
        end else if (have_pri_i || have_sec_i) begin
            merged_o           = have_pri_i ? pri_i : sec_i;
            verdict_o.frame_ok = (merged_o[N-1] == exp_wkc_i);
            verdict_o.status   = verdict_o.frame_ok ? RING_BREAK : RING_FAILED;
        end
    end
endmodule

// File: rtl/ring_frame_merger.sv
module ring_frame_merger
    import rfm_pkg::*;
#(
    parameter int N           = 8,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       init_i,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_last,
    input  logic [7:0] tx_exp_wkc,
    input  logic       pri_valid,
    input  logic [7:0] pri_data,
    input  logic       pri_last,
    input  logic       sec_valid,
    input  logic [7:0] sec_data,
    input  logic       sec_last,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready,
    output logic       out_frame_ok,
    output logic       out_lost,
    output logic [1:0] ring_status
);
    localparam int IW = $clog2(N);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    phase_e            phase;
    logic [IW-1:0]     tx_idx, out_idx;
    logic [TW-1:0]     timer;
    logic [N-1:0][7:0] ref_q, out_buf, merged;
    logic [7:0]        exp_q;
    ring_e             status_q;
    verdict_t          vq, vd;

    logic [1:0]        cap_v, cap_l, cap_have;
    logic [7:0]        cap_d  [2];
    logic [N-1:0][7:0] cap_fr [2];

    assign cap_v = {sec_valid, pri_valid};
    assign cap_l = {sec_last, pri_last};
    assign cap_d[0] = pri_data;
    assign cap_d[1] = sec_data;

    for (genvar p = 0; p < 2; p++) begin : g_port
        rfm_capture #(.N(N)) u_cap (
            .clk        (clk),
            .rst        (rst),
            .clear_i    (phase == PH_IDLE),
            .arm_i      (phase == PH_WAIT),
            .ref_id_i   (ref_q[0]),
            .in_valid_i (cap_v[p]),
            .in_data_i  (cap_d[p]),
            .in_last_i  (cap_l[p]),
            .have_o     (cap_have[p]),
            .frame_o    (cap_fr[p])
        );
    end

    rfm_merge #(.N(N)) u_merge (
        .ref_i      (ref_q),
        .pri_i      (cap_fr[0]),
        .sec_i      (cap_fr[1]),
        .have_pri_i (cap_have[0]),
        .have_sec_i (cap_have[1]),
        .exp_wkc_i  (exp_q),
        .merged_o   (merged),
        .verdict_o  (vd)
    );

    wire window_end = (cap_have == 2'b11) || (timer == TW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tx_idx   <= '0;
            out_idx  <= '0;
            timer    <= '0;
            exp_q    <= '0;
            status_q <= RING_INTACT;
            vq       <= '0;
            ref_q    <= '0;
            out_buf  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (tx_valid) begin
                    for (int i = 0; i < N; i++)
                        if (tx_idx == IW'(i)) ref_q[i] <= tx_data;
                    if (tx_last) begin
                        exp_q  <= tx_exp_wkc;
                        tx_idx <= '0;
                        timer  <= '0;
                        phase  <= PH_WAIT;
                    end else if (tx_idx != IW'(N - 1)) begin
                        tx_idx <= tx_idx + 1'b1;
                    end
                end
                PH_WAIT: begin
                    timer <= timer + 1'b1;
                    if (window_end) begin
                        if (cap_have != 2'b00) begin
                            out_buf  <= merged;
                            vq       <= vd;
                            out_idx  <= '0;
                            status_q <= (status_q == RING_FAILED) ? RING_FAILED : vd.status;
                            phase    <= PH_EMIT;
                        end else begin
                            status_q <= RING_FAILED;
                            phase    <= PH_IDLE;
                        end
                    end
                end
                PH_EMIT: if (out_ready) begin
                    if (out_idx == IW'(N - 1)) phase <= PH_IDLE;
                    else                       out_idx <= out_idx + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
            if (init_i) status_q <= RING_INTACT;
        end
    end

    assign out_valid    = (phase == PH_EMIT);
    assign out_data     = out_buf[out_idx];
    assign out_last     = out_valid && (out_idx == IW'(N - 1));
    assign out_frame_ok = vq.frame_ok;
    assign out_lost     = vq.lost;
    assign ring_status  = status_q;

    // R11
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ring_status == 2'(RING_FAILED) && !init_i |=> ring_status == 2'(RING_FAILED));
    // R10
    init_clears_chk: assert property (@(posedge clk) disable iff (rst)
        init_i |=> ring_status == 2'(RING_INTACT));
    // R4
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> $stable(out_frame_ok) && $stable(out_lost));
endmodule

// File: tb/ring_frame_merger_tb_top.sv
module ring_frame_merger_tb_top;
    localparam int N  = 8;
    localparam int TO = 64;
    typedef logic [N-1:0][7:0] frame_t;

    logic clk = 1'b0, rst = 1'b1, init_i = 1'b0;
    logic tx_valid = 0, tx_last = 0, pri_valid = 0, pri_last = 0, sec_valid = 0, sec_last = 0;
    logic [7:0] tx_data = 0, tx_exp_wkc = 0, pri_data = 0, sec_data = 0;
    logic out_valid, out_last, out_ready = 0, out_frame_ok, out_lost;
    logic [7:0] out_data;
    logic [1:0] ring_status;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [1:0] model_st = 2'd0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ring_frame_merger #(.N(N), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst(rst), .init_i(init_i),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_exp_wkc(tx_exp_wkc),
        .pri_valid(pri_valid), .pri_data(pri_data), .pri_last(pri_last),
        .sec_valid(sec_valid), .sec_data(sec_data), .sec_last(sec_last),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .out_frame_ok(out_frame_ok), .out_lost(out_lost), .ring_status(ring_status));

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic frame_t model_merge(frame_t r, frame_t p, frame_t s);
        frame_t m;
        m[0] = r[0];
        for (int i = 1; i < N - 1; i++)
            m[i] = (p[i] != r[i]) ? p[i] : ((s[i] != r[i]) ? s[i] : r[i]);
        m[N-1] = p[N-1] + s[N-1];
        return m;
    endfunction

    function automatic logic [1:0] model_status(frame_t r, frame_t s, logic [7:0] sum, logic [7:0] e);
        bit clean = 1;
        for (int i = 1; i < N - 1; i++) if (s[i] != r[i]) clean = 0;
        if (sum != e) return 2'd2;
        if (clean && s[N-1] == 8'd0) return 2'd0;
        return 2'd1;
    endfunction

    task automatic send_tx(input frame_t f, input logic [7:0] e);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            tx_valid = 1; tx_data = f[i]; tx_last = (i == N - 1); tx_exp_wkc = e;
        end
        @(negedge clk);
        tx_valid = 0; tx_last = 0;
    endtask

    task automatic send_port(input int port, input frame_t f, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (port == 0) begin pri_valid = 1; pri_data = f[i]; pri_last = (i == len - 1); end
            else           begin sec_valid = 1; sec_data = f[i]; sec_last = (i == len - 1); end
        end
        @(negedge clk);
        pri_valid = 0; pri_last = 0; sec_valid = 0; sec_last = 0;
    endtask

    task automatic collect(input string req, output frame_t got, output bit ok, output bit lost);
        int idx = 0;
        bit stalled = 0;
        logic [7:0] held = 0;
        got = '0; ok = 0; lost = 0;
        for (int c = 0; c < 600 && idx < N; c++) begin
            @(negedge clk);
            if (stalled) chk(out_valid && out_data == held, "R11", "stall hold", out_data, held);
            out_ready = ($urandom % 4) != 0;
            #1;
            stalled = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                got[idx] = out_data;
                ok = out_frame_ok; lost = out_lost;
                if (idx == N - 1 || out_last)
                    chk(out_last == (idx == N - 1), "R11", "last marker", out_last, idx);
                idx++;
            end
        end
        @(negedge clk);
        out_ready = 0;
        if (idx < N) chk(0, req, "frame missing", idx, N);
    endtask

    frame_t rf, pf, sf, got, expf;
    bit ok, lost;
    logic [7:0] e, pw, sw;

    task automatic make_ref(input logic [7:0] id);
        rf[0] = id;
        for (int i = 1; i < N - 1; i++) rf[i] = 8'($urandom);
        rf[N-1] = 8'd0;
    endtask

    initial begin
        void'($urandom(32'd1337));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(ring_status == 0, "R1", "status after reset", ring_status, 0);

        // intact ring: primary processes, secondary returns untouched
        make_ref(8'h11); e = 8'd5;
        pf = rf; for (int i = 1; i < N - 1; i++) pf[i] = rf[i] ^ 8'h5A; pf[N-1] = e;
        sf = rf;
        send_tx(rf, e); send_port(0, pf, N); send_port(1, sf, N);
        collect("R5", got, ok, lost);
        expf = model_merge(rf, pf, sf);
        chk(got == expf, "R3", "intact merge", got, expf);
        chk(ok && !lost, "R4", "intact ok/lost", {ok, lost}, 2'b10);
        chk(ring_status == 0, "R5", "intact status", ring_status, 0);

        // random single-break frames
        for (int k = 0; k < 10; k++) begin
            make_ref(8'(8'h20 + k));
            e = 8'(2 + $urandom % 20);
            pw = 8'(1 + $urandom % (e - 1)); sw = e - pw;
            pf = rf; sf = rf;
            for (int i = 1; i < N - 1; i++) begin
                int own = $urandom % 4;
                if (own == 1 || own == 3) pf[i] = rf[i] ^ 8'(1 + $urandom % 255);
                if (own == 2 || own == 3) sf[i] = rf[i] ^ 8'(1 + $urandom % 255);
            end
            pf[N-1] = pw; sf[N-1] = sw;
            send_tx(rf, e);
            if (k % 2 == 0) begin send_port(0, pf, N); send_port(1, sf, N); end
            else            begin send_port(1, sf, N); send_port(0, pf, N); end
            collect("R3", got, ok, lost);
            expf = model_merge(rf, pf, sf);
            chk(got == expf, "R3", "break merge", got, expf);
            chk(ok == 1 && lost == 0, "R4", "break ok", {ok, lost}, 2'b10);
            chk(ring_status == model_status(rf, sf, pw + sw, e), "R6", "break status",
                ring_status, model_status(rf, sf, pw + sw, e));
        end

        // repaired ring returns to intact
        make_ref(8'h40); e = 8'd3;
        pf = rf; pf[2] = rf[2] ^ 8'hFF; pf[N-1] = e; sf = rf;
        send_tx(rf, e); send_port(0, pf, N); send_port(1, sf, N);
        collect("R10", got, ok, lost);
        chk(ring_status == 0, "R10", "repair to intact", ring_status, 0);

        // secondary with wrong id ignored: timeout with primary alone
        make_ref(8'h50); e = 8'd4;
        pf = rf; pf[1] = rf[1] ^ 8'h01; pf[N-1] = e;
        sf = rf; sf[0] = 8'h51; sf[N-1] = 8'd0;
        send_tx(rf, e); send_port(0, pf, N); send_port(1, sf, N);
        collect("R8", got, ok, lost);
        chk(got == pf, "R2", "wrong id ignored, primary verbatim", got, pf);
        chk(ok && lost, "R8", "lost flag", {ok, lost}, 2'b11);
        chk(ring_status == 1, "R8", "single copy status", ring_status, 1);

        // short primary ignored: secondary alone used
        make_ref(8'h60); e = 8'd6;
        pf = rf; pf[N-1] = e;
        sf = rf; sf[3] = rf[3] ^ 8'h80; sf[N-1] = e;
        send_tx(rf, e); send_port(0, pf, N - 1); send_port(1, sf, N);
        collect("R2", got, ok, lost);
        chk(got == sf, "R2", "short frame ignored", got, sf);
        chk(ok && lost, "R8", "secondary alone flags", {ok, lost}, 2'b11);

        // working counter short -> failed
        make_ref(8'h70); e = 8'd9;
        pf = rf; pf[1] = rf[1] ^ 8'h3C; pf[N-1] = 8'd3;
        sf = rf; sf[4] = rf[4] ^ 8'h0F; sf[N-1] = 8'd2;
        send_tx(rf, e); send_port(0, pf, N); send_port(1, sf, N);
        collect("R7", got, ok, lost);
        expf = model_merge(rf, pf, sf);
        chk(got == expf, "R7", "short sum merge", got, expf);
        chk(!ok && !lost, "R7", "frame not ok", {ok, lost}, 2'b00);
        chk(ring_status == 2, "R7", "failed status", ring_status, 2);

        // good frame does not clear failed
        make_ref(8'h71); e = 8'd4;
        pf = rf; pf[N-1] = 8'd2; sf = rf; sf[N-1] = 8'd2; pf[5] = rf[5] ^ 8'h10;
        send_tx(rf, e); send_port(0, pf, N); send_port(1, sf, N);
        collect("R10", got, ok, lost);
        chk(ok, "R4", "good frame ok", ok, 1);
        chk(ring_status == 2, "R10", "failed sticky", ring_status, 2);

        @(negedge clk); init_i = 1;
        @(negedge clk); init_i = 0;
        chk(ring_status == 0, "R10", "init clears", ring_status, 0);

        // neither copy returns
        make_ref(8'h80); e = 8'd2;
        send_tx(rf, e);
        begin
            bit seen = 0;
            for (int c = 0; c < TO + 20; c++) begin
                @(negedge clk);
                if (out_valid) seen = 1;
            end
            chk(!seen, "R9", "no output frame", seen, 0);
        end
        chk(ring_status == 2, "R9", "status failed", ring_status, 2);
        @(negedge clk); init_i = 1;
        @(negedge clk); init_i = 0;
        chk(ring_status == 0, "R10", "init after loss", ring_status, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule